// File: doc/BRIEF.md
# Codec Configuration Sequencer with Serial Word Transmitter

This block starts up an external audio codec and then feeds it samples over a 16-bit synchronous serial transmit link. A start pulse holds the codec's active-low reset line down and clears the transmit holding word to zero. Only then does it release the codec. It next loads four configuration words. Each configuration word is sent as a pair: first a secondary-communication request word, then the value itself. No word is loaded until the previous one has been shifted out completely.

The link runs in non-continuous mode with a variable data rate. The codec supplies an active-low frame sync, and a loaded word stays pending until the next falling edge of that frame sync. The word then goes out most significant bit first, one bit per clock, on an active-high data line. When the last configuration word has been shifted, busy drops and the block accepts sample words with a valid/ready handshake. Each accepted sample is sent as a primary communication, with its two low bits forced to zero.

Top module: `codec_cfg_seq`

## Requirements
- R1: After reset, codec_rst_no_o is 0, busy_o is 0, ready_o is 0 and tx_data_o is 0.
- R2: A start pulse accepted at edge k sets busy_o=1 and codec_rst_no_o=0 after edge k. The transmit holding word is cleared to 0 at edge k+1. codec_rst_no_o rises to 1 at edge k+2, which is only after that clear.
- R3: After start, exactly eight words are transmitted in this order: 0x0003, cfg word 0, 0x0003, cfg word 1, 0x0003, cfg word 2, 0x0003, cfg word 3. Cfg word i is cfg_i[16*i+15:16*i], and the defaults are 0x162C, 0x0001, 0x4892, 0x0067.
- R4: Every configuration word is immediately preceded on the link by its own request word 0x0003. Its two low bits are set.
- R5: A new word is loaded only when the previous word has fully finished shifting. No load occurs while a word is pending or shifting.
- R6: A pending word starts shifting on the clock edge that sees tx_fs_ni low after it was high. tx_data_o then carries bit 15 down to bit 0 on the next 16 cycles, active high.
- R7: Without a falling frame sync, a pending word is not shifted: tx_data_o stays 0 and busy_o stays 1.
- R8: busy_o falls only after the fourth configuration word has been shifted out. From then on ready_o is 1 whenever the transmitter is empty, and codec_rst_no_o remains 1.
- R9: A sample on smp_i with smp_valid_i=1 while ready_o=1 is transmitted at the next frame sync as {smp_i[15:2], 2'b00}.
- R10: A start pulse while busy_o=1 is ignored. The codec reset stays released and the word sequence continues unchanged.
- R11: A falling frame sync with no word pending produces no data: tx_data_o stays 0.
- R12: A start pulse while busy_o=0 after configuration restarts the sequence. The next cycle shows busy_o=1 and codec_rst_no_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the configuration sequence |
| cfg_i | input | 64 | Four configuration words; word i in bits [16*i+15:16*i] |
| smp_i | input | 16 | Sample word |
| smp_valid_i | input | 1 | Sample word valid |
| ready_o | output | 1 | Sample word accepted this cycle if valid |
| busy_o | output | 1 | Configuration sequence in progress |
| codec_rst_no_o | output | 1 | Active-low codec reset |
| tx_fs_ni | input | 1 | Active-low frame sync from the codec |
| tx_data_o | output | 1 | Serial transmit data, MSB first, active high |

## Verification
The assertions check on every cycle that no word is loaded into a busy transmitter, that request and configuration loads alternate, and that the codec reset rises only after the holding word is zero. They also check that a start during configuration neither ends the busy phase nor drops the codec reset, and that sample words carry low bits 00. The exact eight-word order and the MSB-first bit order can only be shown by the bench's scenarios. The same holds for stalling on a missing frame sync, empty frames, sample formatting and a restart after configuration. The bench shows these by capturing every frame at the pin.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  typedef enum logic [1:0] {TX_EMPTY, TX_PEND, TX_SHIFT} tx_st_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CLR, SQ_REL, SQ_LREQ, SQ_LDAT, SQ_DRAIN, SQ_RUN
  } sq_st_e;
endpackage

// File: rtl/cc_tx_shifter.sv
module cc_tx_shifter
  import codec_cfg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         fs_ni,
  output logic         idle_o,
  output logic [W-1:0] held_o,
  output logic         dx_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  tx_st_e        st_q;
  logic [W-1:0]  hold_q, sreg_q;
  logic [CW-1:0] cnt_q;
  logic          fs_q;
  logic          fs_fall;

  assign fs_fall = fs_q & ~fs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_EMPTY;
      hold_q <= '0;
      sreg_q <= '0;
      cnt_q  <= '0;
      fs_q   <= 1'b1;
    end else begin
      fs_q <= fs_ni;
      if (clr_i) begin
        st_q   <= TX_EMPTY;
        hold_q <= '0;
      end else begin
        unique case (st_q)
          TX_EMPTY: if (load_i) begin
            hold_q <= word_i;
            st_q   <= TX_PEND;
          end
          TX_PEND: if (fs_fall) begin
            sreg_q <= hold_q;
            cnt_q  <= '0;
            st_q   <= TX_SHIFT;
          end
          TX_SHIFT: begin
            sreg_q <= sreg_q << 1;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == LAST) st_q <= TX_EMPTY;
          end
          default: st_q <= TX_EMPTY;
        endcase
      end
    end
  end

  assign idle_o = (st_q == TX_EMPTY);
  assign held_o = hold_q;
  assign dx_o   = (st_q == TX_SHIFT) & sreg_q[W-1];

  AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> st_q == TX_EMPTY); // R5
  AST_NO_DATA_UNSHIFTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_PEND && fs_ni) |=> !dx_o); // R7
endmodule

// File: rtl/cc_sequencer.sv
module cc_sequencer
  import codec_cfg_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4,
  parameter logic [W-1:0] REQ = W'(3)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*W-1:0] cfg_i,
  input  logic [W-1:0]   smp_i,
  input  logic           smp_valid_i,
  input  logic           tx_idle_i,
  output logic           tx_clr_o,
  output logic           tx_load_o,
  output logic [W-1:0]   tx_word_o,
  output logic           ready_o,
  output logic           busy_o,
  output logic           codec_rst_no_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  sq_st_e        st_q;
  logic [IW-1:0] idx_q;
  logic          crst_q;
  logic          start_acc;
  logic          want_data_q;
  logic [W-1:0]  cfg_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_cfg
    assign cfg_arr[g] = cfg_i[g*W +: W];
  end

  assign start_acc = start_i & (st_q == SQ_IDLE || st_q == SQ_RUN);
  assign busy_o    = !(st_q == SQ_IDLE || st_q == SQ_RUN);
  assign ready_o   = (st_q == SQ_RUN) & tx_idle_i;
  assign codec_rst_no_o = crst_q;

  always_comb begin
    tx_clr_o  = (st_q == SQ_CLR);
    tx_load_o = 1'b0;
    tx_word_o = '0;
    unique case (st_q)
      SQ_LREQ: begin tx_load_o = tx_idle_i; tx_word_o = REQ; end
      SQ_LDAT: begin tx_load_o = tx_idle_i; tx_word_o = cfg_arr[idx_q]; end
      SQ_RUN:  begin
        tx_load_o = tx_idle_i & smp_valid_i;
        tx_word_o = {smp_i[W-1:2], 2'b00};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      crst_q <= 1'b0;
    end else if (start_acc) begin
      st_q   <= SQ_CLR;
      idx_q  <= '0;
      crst_q <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_CLR:  st_q <= SQ_REL;
        SQ_REL:  begin crst_q <= 1'b1; st_q <= SQ_LREQ; end
        SQ_LREQ: if (tx_idle_i) st_q <= SQ_LDAT;
        SQ_LDAT: if (tx_idle_i) begin
          idx_q <= idx_q + 1'b1;
          st_q  <= (idx_q == LAST) ? SQ_DRAIN : SQ_LREQ;
        end
        SQ_DRAIN: if (tx_idle_i) st_q <= SQ_RUN;
        default: ;
      endcase
    end
  end

  // tracks request/data alternation for the checks below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          want_data_q <= 1'b0;
    else if (tx_clr_o)    want_data_q <= 1'b0;
    else if (tx_load_o && busy_o) want_data_q <= (st_q == SQ_LREQ);
  end

  AST_DATA_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_o && st_q == SQ_LDAT) |-> want_data_q); // R4
  AST_REQ_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_o && st_q == SQ_LREQ) |-> !want_data_q); // R4
  AST_START_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && codec_rst_no_o) |=> (busy_o && codec_rst_no_o)); // R10
  AST_RUN_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> codec_rst_no_o); // R8
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 4,
  parameter logic [W-1:0] REQ = W'(3)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*W-1:0] cfg_i,
  input  logic [W-1:0]   smp_i,
  input  logic           smp_valid_i,
  output logic           ready_o,
  output logic           busy_o,
  output logic           codec_rst_no_o,
  input  logic           tx_fs_ni,
  output logic           tx_data_o
);
  logic         tx_idle, tx_clr, tx_load;
  logic [W-1:0] tx_word, tx_held;

  cc_sequencer #(.W(W), .N(N), .REQ(REQ)) i_seq (
    .clk_i, .rst_ni, .start_i, .cfg_i, .smp_i, .smp_valid_i,
    .tx_idle_i(tx_idle), .tx_clr_o(tx_clr), .tx_load_o(tx_load),
    .tx_word_o(tx_word), .ready_o, .busy_o, .codec_rst_no_o
  );

  cc_tx_shifter #(.W(W)) i_tx (
    .clk_i, .rst_ni, .clr_i(tx_clr), .load_i(tx_load), .word_i(tx_word),
    .fs_ni(tx_fs_ni), .idle_o(tx_idle), .held_o(tx_held), .dx_o(tx_data_o)
  );

  AST_RELEASE_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(codec_rst_no_o) |-> $past(tx_held) == '0); // R2
  AST_SAMPLE_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load && !busy_o) |-> tx_word[1:0] == 2'b00); // R9
endmodule

// File: tb/test_codec_cfg_seq.sv
module test_codec_cfg_seq;
  localparam int CLK_P = 10;
  localparam int W = 16;
  localparam logic [63:0] CFG = 64'h0067_4892_0001_162C;
  localparam logic [15:0] EXP_SEQ [8] = '{16'h0003, 16'h162C, 16'h0003, 16'h0001,
                                          16'h0003, 16'h4892, 16'h0003, 16'h0067};
  localparam logic [15:0] SMP_IN  [4] = '{16'hA5A7, 16'h0003, 16'hFFFF, 16'h1234};
  localparam logic [15:0] SMP_EXP [4] = '{16'hA5A4, 16'h0000, 16'hFFFC, 16'h1234};

  logic clk = 0, rst_n = 0, start = 0, smp_valid = 0, fs_n = 1;
  logic [15:0] smp = '0;
  logic ready, busy, crst_n, dx;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  codec_cfg_seq i_codec_cfg_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_i(CFG), .smp_i(smp),
    .smp_valid_i(smp_valid), .ready_o(ready), .busy_o(busy),
    .codec_rst_no_o(crst_n), .tx_fs_ni(fs_n), .tx_data_o(dx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic grab(output logic [15:0] w);
    @(negedge clk); fs_n = 0;
    w = '0;
    for (int b = 0; b < 16; b++) begin
      @(negedge clk); fs_n = 1;
      w = {w[14:0], dx};
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    logic seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 crst", crst_n, 0); chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 0); chk("R1 dx", dx, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R11 frame with nothing pending before start
    grab(w); chk("R11 idle frame", w, 16'h0000);
    // R2 start timing
    start = 1; @(negedge clk); start = 0;
    chk("R2 busy", busy, 1); chk("R2 crst low", crst_n, 0);
    @(negedge clk); chk("R2 crst still low", crst_n, 0);
    @(negedge clk); chk("R2 crst released", crst_n, 1);
    // R7 no frame sync: nothing shifts
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen |= dx; end
    chk("R7 dx quiet", seen, 0); chk("R7 busy held", busy, 1);
    // R3 R4 R6 word sequence walked from table
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        start = 1; @(negedge clk); start = 0; // R10 start while busy
        @(negedge clk);
        chk("R10 crst kept", crst_n, 1); chk("R10 busy kept", busy, 1);
      end
      grab(w);
      chk($sformatf("R3/R4/R6 word %0d", i), w, EXP_SEQ[i]);
      if (i < 7) chk("R8 busy mid-config", busy, 1);
    end
    // R8 busy drops after last word
    chk("R8 busy low", busy, 0); chk("R8 ready", ready, 1); chk("R8 crst", crst_n, 1);
    // R11 frame with no sample pending
    grab(w); chk("R11 empty frame", w, 16'h0000); chk("R11 ready", ready, 1);
    // R9 samples
    for (int i = 0; i < 4; i++) begin
      smp = SMP_IN[i]; smp_valid = 1;
      @(negedge clk); smp_valid = 0;
      chk("R5 not ready while pending", ready, 0);
      grab(w);
      chk($sformatf("R9 sample %0d", i), w, SMP_EXP[i]);
    end
    // R12 restart after configuration
    start = 1; @(negedge clk); start = 0;
    chk("R12 busy", busy, 1); chk("R12 crst low", crst_n, 0);
    @(negedge clk); @(negedge clk);
    grab(w); chk("R12 first word", w, 16'h0003);
    finish_run();
  end
endmodule